// File: doc/BRIEF.md
# Disk Sector Address Sequencer and Checker

This block runs once before every sector of a multi-sector disk transfer. It takes the controller's six-bit head/sector register, the cylinder the host asked for, the cylinder the selected drive currently sits on, the platter select, the drive geometry type, the drive's attached and write-protect state, the operation code and a flag marking the first sector of the transfer. From these it either rejects the sector with an error code or produces a linear sector number for the media side.

On acceptance it also produces the head/sector value for the next sector of the run. It steps the sector field. At the end of a 24-sector track it wraps the sector to 0 and flips the head bit. When the head bit comes back to 0 on a later sector of the same transfer, that sector is refused as a cylinder overflow. A host request for cylinder 0 that does not match the drive's position is not an error: the block signals the drive to re-home to cylinder 0 and computes the address on that cylinder.

A small combinational padding unit sits next to the sequencer. It gives the byte to store at each position of a 256-byte sector when the host supplied fewer bytes than that. On writes the last supplied byte repeats. On reads the missing bytes are zero.

Top module: `sector_addr_seq`

## Requirements
- R1: A check request sampled on a rising edge (req_valid_i high) yields done_o high for exactly the next cycle. While done_o is low, err_o, lba_o, hs_o, first_o and rehome_o are all 0.
- R2: Error code 1 (transfer error) is reported when attached_i is 0, or when cmd_i is 2 (write) and wprot_i is 1. A read (cmd_i 1) or read-check (cmd_i 3) on a protected drive is not refused.
- R3: When req_cyl_i differs from drv_cyl_i and req_cyl_i is 0, no error is raised for the cylinder, rehome_o is 1, and cylinder 0 is used for the address. Any other mismatch reports error code 2 (address compare fail) with rehome_o 0.
- R4: A sector field (hs_i bits 4:0) of 24 or more reports error code 3 (overrun).
- R5: When first_i is 0 and hs_i is 0 (head 0, sector 0), error code 4 (cylinder overflow) is reported. With first_i 1 the same address is accepted.
- R6: On acceptance (error code 0), lba_o equals ((platter x C + cyl) x 2 + head) x 24 + sector, where C is 203 for dtype_i 0 and 408 for dtype_i 1, head is hs_i bit 5, and cyl is the cylinder in use per R3.
- R7: On acceptance, hs_o is hs_i plus one when the sector is below 23. At sector 23 the sector field of hs_o is 0 and bit 5 is the inverse of hs_i bit 5.
- R8: On acceptance first_o is 0. On any error, hs_o equals hs_i, first_o equals first_i and lba_o is 0.
- R9: The error checks rank transfer error over cylinder check over overrun over cylinder overflow. A re-home under R3 still occurs when a lower-ranked check then fails.
- R10: The padding output pad_byte_o equals pad_byte_i when pad_idx_i < pad_cnt_i. Otherwise it equals pad_last_i when pad_write_i is 1, and 0 when pad_write_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Check request for one sector |
| hs_i | input | 6 | Head/sector register: bit 5 head, bits 4:0 sector |
| req_cyl_i | input | CYL_W | Cylinder requested by the host |
| drv_cyl_i | input | CYL_W | Cylinder the drive is positioned on |
| platter_i | input | 1 | Platter select |
| dtype_i | input | 1 | Drive geometry type (0: 203 cylinders, 1: 408) |
| attached_i | input | 1 | Drive has media and is online |
| wprot_i | input | 1 | Drive is write protected |
| cmd_i | input | 2 | Operation: 1 read, 2 write, 3 read check |
| first_i | input | 1 | This is the first sector of the transfer |
| pad_idx_i | input | IDX_W | Byte position within the sector |
| pad_cnt_i | input | IDX_W+1 | Number of bytes the host supplied |
| pad_byte_i | input | 8 | Supplied byte for this position |
| pad_last_i | input | 8 | Last byte the host supplied |
| pad_write_i | input | 1 | Padding for a write (1) or a read (0) |
| done_o | output | 1 | Check result valid |
| err_o | output | 3 | 0 ok, 1 transfer, 2 address compare, 3 overrun, 4 cylinder overflow |
| lba_o | output | LBA_W | Linear sector number |
| hs_o | output | 6 | Head/sector value for the next sector |
| first_o | output | 1 | Updated first-sector flag |
| rehome_o | output | 1 | Drive must move to cylinder 0 |
| pad_byte_o | output | 8 | Byte to store at pad_idx_i |

## Verification
On every cycle the assertions check the one-cycle request-to-result timing and the quiet outputs between results. They also check that a missing drive or a protected write always ends in a transfer error, that a refused sector leaves the head/sector value and first flag untouched, that an accepted sector clears the first flag and stays within the track, and that a re-home is only ever caused by a cylinder-0 request. The bench scenarios cover the rest: the exact linear address for both drive types and both platters, the sector and head wrap, the re-home taking cylinder 0 into the address, the ranking between error checks, and the padding bytes for short reads and writes.

// File: rtl/sas_pkg.sv
package sas_pkg;

  localparam int HS_W     = 6;
  localparam int SEC_W    = 5;
  localparam int HEAD_BIT = 5;

  typedef enum logic [2:0] {
    SERR_NONE  = 3'd0,
    SERR_XFER  = 3'd1,
    SERR_ADDR  = 3'd2,
    SERR_RANGE = 3'd3,
    SERR_WRAP  = 3'd4
  } serr_e;

  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;
  localparam logic [1:0] OP_RCHK  = 2'd3;

  // Next head/sector value after an accepted sector.
  function automatic logic [HS_W-1:0] hs_step(input logic [HS_W-1:0] hs,
                                               input logic [SEC_W-1:0] last_sec);
    logic [HS_W-1:0] r;
    if (hs[SEC_W-1:0] == last_sec)
      r = {~hs[HEAD_BIT], {SEC_W{1'b0}}};
    else
      r = hs + HS_W'(1);
    return r;
  endfunction

endpackage

// File: rtl/sas_check.sv
module sas_check
  import sas_pkg::*;
#(
  parameter int CYL_W = 16,
  parameter int SECTS = 24
) (
  input  logic             attached_i,
  input  logic             wprot_i,
  input  logic             is_write_i,
  input  logic [CYL_W-1:0] req_cyl_i,
  input  logic [CYL_W-1:0] drv_cyl_i,
  input  logic [HS_W-1:0]  hs_i,
  input  logic             first_i,
  output serr_e            err_o,
  output logic             rehome_o,
  output logic [CYL_W-1:0] cyl_o,
  output logic [HS_W-1:0]  hs_next_o,
  output logic             wrap_o
);

  localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SECTS - 1);

  logic [SEC_W-1:0] sec;
  logic             gate_bad;
  logic             cyl_miss;
  logic             zero_req;
  logic             sec_bad;
  logic             ovf_bad;

  always_comb begin
    sec      = hs_i[SEC_W-1:0];
    gate_bad = !attached_i || (wprot_i && is_write_i);
    cyl_miss = (req_cyl_i != drv_cyl_i);
    zero_req = (req_cyl_i == '0);
    sec_bad  = (sec > LAST_SEC);
    ovf_bad  = !first_i && (hs_i == '0);

    // Ranked checks: gate, cylinder, sector range, overflow.
    if (gate_bad)                   err_o = SERR_XFER;
    else if (cyl_miss && !zero_req) err_o = SERR_ADDR;
    else if (sec_bad)               err_o = SERR_RANGE;
    else if (ovf_bad)               err_o = SERR_WRAP;
    else                            err_o = SERR_NONE;

    rehome_o  = !gate_bad && cyl_miss && zero_req;
    cyl_o     = rehome_o ? '0 : drv_cyl_i;
    wrap_o    = (sec == LAST_SEC);
    hs_next_o = hs_step(hs_i, LAST_SEC);
  end

endmodule

// File: rtl/sas_addr.sv
module sas_addr
  import sas_pkg::*;
#(
  parameter int CYL_W   = 16,
  parameter int LBA_W   = 17,
  parameter int CYLS_T0 = 203,
  parameter int CYLS_T1 = 408,
  parameter int SURFS   = 2,
  parameter int SECTS   = 24
) (
  input  logic             platter_i,
  input  logic             dtype_i,
  input  logic [CYL_W-1:0] cyl_i,
  input  logic [HS_W-1:0]  hs_i,
  output logic [LBA_W-1:0] lba_o
);

  function automatic logic [LBA_W-1:0] linear(input logic             plat,
                                              input logic [LBA_W-1:0] ncyl,
                                              input logic [CYL_W-1:0] cyl,
                                              input logic             head,
                                              input logic [SEC_W-1:0] sec);
    logic [LBA_W-1:0] trk;
    logic [LBA_W-1:0] srf;
    trk = (plat ? ncyl : '0) + LBA_W'(cyl);
    srf = trk * LBA_W'(SURFS) + LBA_W'(head);
    return srf * LBA_W'(SECTS) + LBA_W'(sec);
  endfunction

  logic [LBA_W-1:0] ncyl;

  always_comb begin
    ncyl  = dtype_i ? LBA_W'(CYLS_T1) : LBA_W'(CYLS_T0);
    lba_o = linear(platter_i, ncyl, cyl_i, hs_i[HEAD_BIT], hs_i[SEC_W-1:0]);
  end

endmodule

// File: rtl/sas_fill.sv
module sas_fill #(
  parameter int BYTES = 256,
  parameter int IDX_W = $clog2(BYTES),
  parameter int CNT_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [7:0]       byte_i,
  input  logic [7:0]       last_i,
  input  logic             write_i,
  output logic [7:0]       byte_o
);

  logic supplied;

  always_comb begin
    supplied = (CNT_W'(idx_i) < cnt_i);
    if (supplied)     byte_o = byte_i;
    else if (write_i) byte_o = last_i;
    else              byte_o = 8'h00;
  end

endmodule

// File: rtl/sector_addr_seq.sv
module sector_addr_seq
  import sas_pkg::*;
#(
  parameter int CYL_W   = 16,
  parameter int LBA_W   = 17,
  parameter int CYLS_T0 = 203,
  parameter int CYLS_T1 = 408,
  parameter int SURFS   = 2,
  parameter int SECTS   = 24,
  parameter int BYTES   = 256,
  localparam int IDX_W  = $clog2(BYTES),
  localparam int CNT_W  = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [5:0]       hs_i,
  input  logic [CYL_W-1:0] req_cyl_i,
  input  logic [CYL_W-1:0] drv_cyl_i,
  input  logic             platter_i,
  input  logic             dtype_i,
  input  logic             attached_i,
  input  logic             wprot_i,
  input  logic [1:0]       cmd_i,
  input  logic             first_i,
  input  logic [IDX_W-1:0] pad_idx_i,
  input  logic [CNT_W-1:0] pad_cnt_i,
  input  logic [7:0]       pad_byte_i,
  input  logic [7:0]       pad_last_i,
  input  logic             pad_write_i,
  output logic             done_o,
  output logic [2:0]       err_o,
  output logic [LBA_W-1:0] lba_o,
  output logic [5:0]       hs_o,
  output logic             first_o,
  output logic             rehome_o,
  output logic [7:0]       pad_byte_o
);

  // Named internal events
  serr_e            chk_err;
  logic             chk_rehome;
  logic [CYL_W-1:0] chk_cyl;
  logic [HS_W-1:0]  chk_hs_next;
  logic             chk_wrap;
  logic             chk_ok;
  logic [LBA_W-1:0] addr_lba;

  sas_check #(.CYL_W(CYL_W), .SECTS(SECTS)) u_check (
    .attached_i (attached_i),
    .wprot_i    (wprot_i),
    .is_write_i (cmd_i == OP_WRITE),
    .req_cyl_i  (req_cyl_i),
    .drv_cyl_i  (drv_cyl_i),
    .hs_i       (hs_i),
    .first_i    (first_i),
    .err_o      (chk_err),
    .rehome_o   (chk_rehome),
    .cyl_o      (chk_cyl),
    .hs_next_o  (chk_hs_next),
    .wrap_o     (chk_wrap)
  );

  sas_addr #(
    .CYL_W(CYL_W), .LBA_W(LBA_W), .CYLS_T0(CYLS_T0), .CYLS_T1(CYLS_T1),
    .SURFS(SURFS), .SECTS(SECTS)
  ) u_addr (
    .platter_i (platter_i),
    .dtype_i   (dtype_i),
    .cyl_i     (chk_cyl),
    .hs_i      (hs_i),
    .lba_o     (addr_lba)
  );

  sas_fill #(.BYTES(BYTES)) u_fill (
    .idx_i   (pad_idx_i),
    .cnt_i   (pad_cnt_i),
    .byte_i  (pad_byte_i),
    .last_i  (pad_last_i),
    .write_i (pad_write_i),
    .byte_o  (pad_byte_o)
  );

  assign chk_ok = (chk_err == SERR_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      err_o    <= 3'd0;
      lba_o    <= '0;
      hs_o     <= '0;
      first_o  <= 1'b0;
      rehome_o <= 1'b0;
    end else if (req_valid_i) begin
      done_o   <= 1'b1;
      err_o    <= chk_err;
      lba_o    <= chk_ok ? addr_lba : '0;
      hs_o     <= chk_ok ? chk_hs_next : hs_i;
      first_o  <= chk_ok ? 1'b0 : first_i;
      rehome_o <= chk_rehome;
    end else begin
      done_o   <= 1'b0;
      err_o    <= 3'd0;
      lba_o    <= '0;
      hs_o     <= '0;
      first_o  <= 1'b0;
      rehome_o <= 1'b0;
    end
  end

endmodule

// File: rtl/sas_chk.sv
module sas_chk #(
  parameter int CYL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid_i,
  input logic             attached_i,
  input logic             wprot_i,
  input logic [1:0]       cmd_i,
  input logic             first_i,
  input logic [5:0]       hs_i,
  input logic [CYL_W-1:0] req_cyl_i,
  input logic             done_o,
  input logic [2:0]       err_o,
  input logic [5:0]       hs_o,
  input logic             first_o,
  input logic             rehome_o,
  input logic             chk_wrap
);

  // R1
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> done_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (err_o == 3'd0 && hs_o == 6'd0 && !rehome_o && !first_o));

  // R2
  gate_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (!attached_i || (wprot_i && cmd_i == 2'd2))) |=> (err_o == 3'd1));

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o != 3'd0) |-> (hs_o == $past(hs_i) && first_o == $past(first_i)));

  // R8
  ok_clears_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == 3'd0) |-> !first_o);

  // R7
  ok_sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == 3'd0) |-> (hs_o[4:0] < 5'd24));

  // R7
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && chk_wrap) |=> (err_o != 3'd0 || hs_o[4:0] == 5'd0));

  // R3
  rehome_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rehome_o |-> ($past(req_cyl_i) == '0 && err_o != 3'd2));

endmodule

bind sector_addr_seq sas_chk #(.CYL_W(CYL_W)) u_sas_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .attached_i  (attached_i),
  .wprot_i     (wprot_i),
  .cmd_i       (cmd_i),
  .first_i     (first_i),
  .hs_i        (hs_i),
  .req_cyl_i   (req_cyl_i),
  .done_o      (done_o),
  .err_o       (err_o),
  .hs_o        (hs_o),
  .first_o     (first_o),
  .rehome_o    (rehome_o),
  .chk_wrap    (chk_wrap)
);

// File: tb/tb_sector_addr_seq.sv
module tb_sector_addr_seq;

  localparam int CYL_W = 16;
  localparam int LBA_W = 17;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid_i = 1'b0;
  logic [5:0]       hs_i = '0;
  logic [CYL_W-1:0] req_cyl_i = '0;
  logic [CYL_W-1:0] drv_cyl_i = '0;
  logic             platter_i = 1'b0;
  logic             dtype_i = 1'b0;
  logic             attached_i = 1'b1;
  logic             wprot_i = 1'b0;
  logic [1:0]       cmd_i = 2'd1;
  logic             first_i = 1'b1;
  logic [7:0]       pad_idx_i = '0;
  logic [8:0]       pad_cnt_i = '0;
  logic [7:0]       pad_byte_i = '0;
  logic [7:0]       pad_last_i = '0;
  logic             pad_write_i = 1'b0;
  logic             done_o;
  logic [2:0]       err_o;
  logic [LBA_W-1:0] lba_o;
  logic [5:0]       hs_o;
  logic             first_o;
  logic             rehome_o;
  logic [7:0]       pad_byte_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sector_addr_seq dut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_lba(input int plat, input int dtype, input int cyl,
                                 input int head, input int sec);
    int ncyl;
    ncyl = (dtype != 0) ? 408 : 203;
    return plat * ncyl * 48 + cyl * 48 + head * 24 + sec;
  endfunction

  // Drive one request, then sample one cycle later away from the edge.
  task automatic issue(input logic [5:0] hs, input int rcyl, input int dcyl,
                       input logic plat, input logic dt, input logic att,
                       input logic wp, input logic [1:0] cmd, input logic first);
    @(negedge clk);
    hs_i = hs; req_cyl_i = CYL_W'(rcyl); drv_cyl_i = CYL_W'(dcyl);
    platter_i = plat; dtype_i = dt; attached_i = att; wprot_i = wp;
    cmd_i = cmd; first_i = first; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "reset done", int'(done_o), 0);
    check("R1", "reset err", int'(err_o), 0);
    check("R1", "reset hs", int'(hs_o), 0);
  endtask

  task automatic t_basic();
    issue(6'h05, 10, 10, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1);
    check("R1", "done", int'(done_o), 1);
    check("R6", "basic err", int'(err_o), 0);
    check("R6", "basic lba", int'(lba_o), exp_lba(0, 0, 10, 0, 5));
    check("R7", "basic hs", int'(hs_o), 6);
    check("R8", "first cleared", int'(first_o), 0);
    @(negedge clk);
    check("R1", "done one cycle", int'(done_o), 0);
    check("R1", "idle lba", int'(lba_o), 0);
  endtask

  task automatic t_wrap();
    issue(6'h17, 3, 3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0);
    check("R7", "wrap head0 hs", int'(hs_o), 6'h20);
    check("R6", "wrap lba", int'(lba_o), exp_lba(0, 0, 3, 0, 23));
    issue(6'h37, 3, 3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0);
    check("R7", "wrap head1 hs", int'(hs_o), 6'h00);
    check("R6", "head1 lba", int'(lba_o), exp_lba(0, 0, 3, 1, 23));
  endtask

  task automatic t_overflow();
    issue(6'h00, 4, 4, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0);
    check("R5", "overflow err", int'(err_o), 4);
    check("R8", "overflow lba", int'(lba_o), 0);
    check("R8", "overflow first held", int'(first_o), 0);
    issue(6'h00, 4, 4, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1);
    check("R5", "first sector 0 ok", int'(err_o), 0);
    check("R5", "first sector 0 hs", int'(hs_o), 1);
    issue(6'h20, 4, 4, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0);
    check("R5", "head1 sec0 ok", int'(err_o), 0);
  endtask

  task automatic t_range();
    issue(6'h18, 2, 2, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1);
    check("R4", "sector 24 err", int'(err_o), 3);
    check("R8", "sector 24 hs held", int'(hs_o), 6'h18);
    check("R8", "sector 24 first held", int'(first_o), 1);
    issue(6'h3F, 2, 2, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0);
    check("R4", "sector 31 err", int'(err_o), 3);
  endtask

  task automatic t_cylinder();
    issue(6'h02, 5, 7, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1);
    check("R3", "mismatch err", int'(err_o), 2);
    check("R3", "mismatch no rehome", int'(rehome_o), 0);
    issue(6'h02, 0, 9, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1);
    check("R3", "rehome err", int'(err_o), 0);
    check("R3", "rehome flag", int'(rehome_o), 1);
    check("R3", "rehome lba", int'(lba_o), exp_lba(1, 1, 0, 0, 2));
  endtask

  task automatic t_gate();
    issue(6'h01, 1, 1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1);
    check("R2", "not attached", int'(err_o), 1);
    issue(6'h01, 1, 1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1);
    check("R2", "protected write", int'(err_o), 1);
    issue(6'h01, 1, 1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1);
    check("R2", "protected read", int'(err_o), 0);
    issue(6'h01, 1, 1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 1'b1);
    check("R2", "protected read check", int'(err_o), 0);
    issue(6'h01, 1, 1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1);
    check("R2", "unprotected write", int'(err_o), 0);
  endtask

  task automatic t_priority();
    issue(6'h19, 5, 6, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0);
    check("R9", "gate over all", int'(err_o), 1);
    check("R9", "gate blocks rehome", int'(rehome_o), 0);
    issue(6'h19, 5, 6, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0);
    check("R9", "cyl over range", int'(err_o), 2);
    issue(6'h19, 0, 6, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0);
    check("R9", "rehome then range", int'(err_o), 3);
    check("R9", "rehome kept", int'(rehome_o), 1);
    issue(6'h00, 7, 6, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0);
    check("R9", "cyl over overflow", int'(err_o), 2);
  endtask

  task automatic t_geometry();
    issue(6'h2A, 407, 407, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1);
    check("R6", "type1 plat1 lba", int'(lba_o), exp_lba(1, 1, 407, 1, 10));
    issue(6'h2A, 100, 100, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1);
    check("R6", "type0 plat1 lba", int'(lba_o), exp_lba(1, 0, 100, 1, 10));
  endtask

  task automatic t_fill();
    pad_cnt_i = 9'd10; pad_byte_i = 8'hA5; pad_last_i = 8'h3C;
    pad_idx_i = 8'd9; pad_write_i = 1'b1; #1;
    check("R10", "supplied byte", int'(pad_byte_o), 8'hA5);
    pad_idx_i = 8'd10; #1;
    check("R10", "write pad", int'(pad_byte_o), 8'h3C);
    pad_idx_i = 8'd255; pad_write_i = 1'b0; #1;
    check("R10", "read pad", int'(pad_byte_o), 0);
    pad_cnt_i = 9'd256; #1;
    check("R10", "full sector", int'(pad_byte_o), 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_wrap();
    t_overflow();
    t_range();
    t_cylinder();
    t_gate();
    t_priority();
    t_geometry();
    t_fill();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule